// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog with two thresholds. A counter advances by one on each cycle where the slow tick enable is high and the block is enabled. The first threshold, the warning stage, raises a level-high interrupt. The second threshold, the fatal stage, raises a reset request that stays high until the block itself is reset. Software can restart the counter at any time. The two thresholds are independent, so the fatal stage may be set below the warning stage; a fatal threshold of 1 gives an almost immediate reset.

The register port takes single-cycle writes on byte addresses. Reads are combinational on the same address. A parameter picks one of two fixed address maps. The normal software sequence is: disable, restart, program both thresholds, then enable.

Top module: `wdog_two_stage`

## Requirements
- R1: With MAP_SEL=0 the restart, enable, warning-threshold and fatal-threshold registers sit at byte addresses 0x38, 0x40, 0x4C and 0x5C. With MAP_SEL=1 they sit at 0x04, 0x08, 0x10 and 0x14. Any other address reads as 0 and ignores writes.
- R2: The enable register holds bit 0 of the written data and reads back that bit, zero-extended. The counter rises by one on each clock edge where enable is 1 and tick_en is high, and holds otherwise.
- R3: A write of data with bit 0 set to the restart register clears the counter at that clock edge. A write with bit 0 clear has no effect. The restart register reads as 0.
- R4: Each threshold register stores the low CNT_W bits of the written data and reads them back, zero-extended.
- R5: While enabled, warn_irq rises one clock edge after the count is at or above a nonzero warning threshold. It stays high until a restart write clears it at that write's edge, or until the enable register reads 0, which clears it on the following edge.
- R6: While enabled, fatal_rst rises one clock edge after the count is at or above a nonzero fatal threshold. It then holds high through restart and disable writes until rst_n is asserted.
- R7: Once fatal_rst is high, the counter freezes and warn_irq is never newly raised. A fatal threshold below the warning threshold therefore resets with no interrupt.
- R8: Take fatal threshold 1, warning threshold 0, a restart, then an enable, with tick_en high every cycle. fatal_rst is then low after the first clock edge following the enable edge and high after the second.
- R9: A threshold of 0 never fires its stage, whatever the count.
- R10: The counter saturates at 2^CNT_W-1 instead of wrapping, so a stage disabled and re-enabled without a restart fires again at once.
- R11: After reset, warn_irq and fatal_rst are low and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count advance qualifier (slow timer tick) |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| warn_irq | output | 1 | Level-high warning interrupt |
| fatal_rst | output | 1 | Sticky reset request |

## Verification
The in-RTL assertions check properties that must hold on every cycle. These cover: the reset request never drops without rst_n; the interrupt clears after a restart or disable; a zero threshold never fires; the counter holds without a tick and sticks at its maximum; and no interrupt appears once the reset request is up. Other behaviour needs directed scenarios. These include the exact tick on which each stage fires, the fatal-before-warning ordering, the one-tick reset, saturation seen through a re-enable, the second address map and register readback. The bench's cycle model compares against all of these.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic [2:0] {
      WR_NONE,
      WR_RESTART,
      WR_ENABLE,
      WR_WARN_THR,
      WR_FATAL_THR
   } wdog_reg_e;

   // Byte offset of each register for the selected map.
   function automatic int unsigned wdog_offset(input int map_sel, input wdog_reg_e r);
      int unsigned off;
      off = 0;
      if (map_sel == 0) begin
         case (r)
            WR_RESTART:   off = 'h38;
            WR_ENABLE:    off = 'h40;
            WR_WARN_THR:  off = 'h4C;
            WR_FATAL_THR: off = 'h5C;
            default:      off = 0;
         endcase
      end else begin
         case (r)
            WR_RESTART:   off = 'h04;
            WR_ENABLE:    off = 'h08;
            WR_WARN_THR:  off = 'h10;
            WR_FATAL_THR: off = 'h14;
            default:      off = 0;
         endcase
      end
      return off;
   endfunction

   localparam int WDOG_NSTAGE = 2;
   localparam int STG_WARN    = 0;
   localparam int STG_FATAL   = 1;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 28,
   parameter int MAP_SEL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              en_o,
   output logic [CNT_W-1:0]  warn_thr_o,
   output logic [CNT_W-1:0]  fatal_thr_o,
   output logic              restart_o
);

   localparam int unsigned OFF_RST  = wdog_offset(MAP_SEL, WR_RESTART);
   localparam int unsigned OFF_EN   = wdog_offset(MAP_SEL, WR_ENABLE);
   localparam int unsigned OFF_WARN = wdog_offset(MAP_SEL, WR_WARN_THR);
   localparam int unsigned OFF_FAT  = wdog_offset(MAP_SEL, WR_FATAL_THR);
   localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(OFF_RST);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);
   localparam logic [ADDR_W-1:0] A_WARN = ADDR_W'(OFF_WARN);
   localparam logic [ADDR_W-1:0] A_FAT  = ADDR_W'(OFF_FAT);

   generate
      if (MAP_SEL != 0 && MAP_SEL != 1) begin : g_bad_map
         $error("wdog_regs: MAP_SEL must be 0 or 1");
      end
      if ((64'd1 << ADDR_W) <= 64'(OFF_FAT)) begin : g_bad_addr
         $error("wdog_regs: ADDR_W too narrow for the register map");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("wdog_regs: CNT_W must lie in 2..DATA_W");
      end
   endgenerate

   wdog_reg_e sel;
   logic      unused_bits;

   assign unused_bits = ^wdata_i;

   always_comb begin
      if      (addr_i == A_RST)  sel = WR_RESTART;
      else if (addr_i == A_EN)   sel = WR_ENABLE;
      else if (addr_i == A_WARN) sel = WR_WARN_THR;
      else if (addr_i == A_FAT)  sel = WR_FATAL_THR;
      else                       sel = WR_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o        <= 1'b0;
         warn_thr_o  <= '0;
         fatal_thr_o <= '0;
      end else if (wr_i) begin
         case (sel)
            WR_ENABLE:    en_o        <= wdata_i[0];
            WR_WARN_THR:  warn_thr_o  <= wdata_i[CNT_W-1:0];
            WR_FATAL_THR: fatal_thr_o <= wdata_i[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   assign restart_o = wr_i && (sel == WR_RESTART) && wdata_i[0];

   always_comb begin
      case (sel)
         WR_ENABLE:    rdata_o = DATA_W'(en_o);
         WR_WARN_THR:  rdata_o = DATA_W'(warn_thr_o);
         WR_FATAL_THR: rdata_o = DATA_W'(fatal_thr_o);
         default:      rdata_o = '0;
      endcase
   end

   // R4
   thr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(warn_thr_o) && $stable(fatal_thr_o));

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int CNT_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             run_i,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_o <= '0;
      else if (clr_i)                      cnt_o <= '0;
      else if (run_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
   end

   // R10
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o == CNT_MAX && !clr_i) |=> cnt_o == CNT_MAX);

   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !clr_i) |=> $stable(cnt_o));

   // R3
   cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> cnt_o == '0);

endmodule

// File: rtl/wdog_stage.sv
module wdog_stage #(
   parameter int CNT_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] thr_i,
   input  logic             arm_i,
   input  logic             clr_i,
   output logic             fire_o
);

   logic hit;

   assign hit = arm_i && (thr_i != '0) && (cnt_i >= thr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fire_o <= 1'b0;
      else if (clr_i)  fire_o <= 1'b0;
      else if (hit)    fire_o <= 1'b1;
   end

   // R9
   zero_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_i == '0 && !fire_o) |=> !fire_o);

   // R5
   fire_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_o && !clr_i) |=> fire_o);

   // R5
   fire_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !fire_o);

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
   import wdog_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 28,
   parameter int MAP_SEL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              warn_irq,
   output logic              fatal_rst
);

   logic             en;
   logic             restart;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] stg_thr  [WDOG_NSTAGE];
   logic             stg_arm  [WDOG_NSTAGE];
   logic             stg_clr  [WDOG_NSTAGE];
   logic             stg_fire [WDOG_NSTAGE];

   wdog_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .MAP_SEL(MAP_SEL)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (bus_wr),
      .addr_i     (bus_addr),
      .wdata_i    (bus_wdata),
      .rdata_o    (bus_rdata),
      .en_o       (en),
      .warn_thr_o (stg_thr[STG_WARN]),
      .fatal_thr_o(stg_thr[STG_FATAL]),
      .restart_o  (restart)
   );

   wdog_count #(.CNT_W(CNT_W)) u_count (
      .clk  (clk),
      .rst_n(rst_n),
      .clr_i(restart),
      .run_i(en && tick_en && !stg_fire[STG_FATAL]),
      .cnt_o(cnt)
   );

   // Warning stage clears on restart or disable; fatal stage only on reset.
   assign stg_arm[STG_WARN]  = en && !stg_fire[STG_FATAL];
   assign stg_clr[STG_WARN]  = restart || !en;
   assign stg_arm[STG_FATAL] = en;
   assign stg_clr[STG_FATAL] = 1'b0;

   generate
      for (genvar g = 0; g < WDOG_NSTAGE; g++) begin : g_stage
         wdog_stage #(.CNT_W(CNT_W)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt_i (cnt),
            .thr_i (stg_thr[g]),
            .arm_i (stg_arm[g]),
            .clr_i (stg_clr[g]),
            .fire_o(stg_fire[g])
         );
      end
   endgenerate

   assign warn_irq  = stg_fire[STG_WARN];
   assign fatal_rst = stg_fire[STG_FATAL];

   // R6
   fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_rst |=> fatal_rst);

   // R7
   no_warn_after_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fatal_rst && !warn_irq) |=> !warn_irq);

   // R5
   warn_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !warn_irq);

   // R7
   frozen_after_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fatal_rst && !restart) |=> $stable(cnt));

endmodule

// File: tb/sim_wdog_two_stage.sv
module sim_wdog_two_stage;

   localparam int CW = 8;
   localparam int MAXC = (1 << CW) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr = 1'b0;
   logic [7:0]  addr = 8'h40;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        warn, fatal;

   logic        wr1 = 1'b0;
   logic [7:0]  addr1 = 8'h00;
   logic [31:0] wdata1 = '0;
   logic [31:0] rdata1;
   logic        warn1, fatal1;

   int n_cmp = 0;
   int n_bad = 0;
   int tick_mode = 0;
   int phase = 0;

   always #2 clk = ~clk;

   wdog_two_stage #(.ADDR_W(8), .DATA_W(32), .CNT_W(CW), .MAP_SEL(0)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .warn_irq(warn), .fatal_rst(fatal));

   wdog_two_stage #(.ADDR_W(8), .DATA_W(32), .CNT_W(CW), .MAP_SEL(1)) u1 (
      .clk(clk), .rst_n(rst_n), .tick_en(1'b0), .bus_wr(wr1), .bus_addr(addr1),
      .bus_wdata(wdata1), .bus_rdata(rdata1), .warn_irq(warn1), .fatal_rst(fatal1));

   // Reference model state
   int m_cnt, m_warn_t, m_fatal_t;
   bit m_en, m_warn, m_fatal;

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      case (a)
         8'h40:   return 32'(m_en);
         8'h4C:   return 32'(m_warn_t);
         8'h5C:   return 32'(m_fatal_t);
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_warn_t = 0; m_fatal_t = 0;
         m_en = 0; m_warn = 0; m_fatal = 0;
      end else begin
         bit rs, n_warn, n_fatal;
         int n_cnt;
         rs = wr && addr == 8'h38 && wdata[0];
         n_cnt = m_cnt;
         if (rs) n_cnt = 0;
         else if (m_en && tick_en && !m_fatal && m_cnt != MAXC) n_cnt = m_cnt + 1;
         n_fatal = m_fatal || (m_en && m_fatal_t != 0 && m_cnt >= m_fatal_t);
         if (rs || !m_en) n_warn = 0;
         else n_warn = m_warn || (m_en && !m_fatal && m_warn_t != 0 && m_cnt >= m_warn_t);
         if (wr && addr == 8'h40) m_en = wdata[0];
         if (wr && addr == 8'h4C) m_warn_t = int'(wdata[CW-1:0]);
         if (wr && addr == 8'h5C) m_fatal_t = int'(wdata[CW-1:0]);
         m_cnt = n_cnt; m_warn = n_warn; m_fatal = n_fatal;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison against the model
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         chk("R5 warn_irq per-cycle", 32'(warn), 32'(m_warn));
         chk("R6 fatal_rst per-cycle", 32'(fatal), 32'(m_fatal));
         chk("R4 bus_rdata per-cycle", rdata, exp_rd(addr));
      end
   end

   always @(negedge clk) begin
      phase++;
      tick_en = (tick_mode == 1) || (tick_mode == 2 && phase % 3 == 0);
   end

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0; addr = 8'h40;
   endtask

   task automatic wr_reg1(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); wr1 = 1'b1; addr1 = a; wdata1 = d;
      @(negedge clk); wr1 = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
      @(negedge clk); addr = a; #1;
      chk(tag, rdata, e);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(4 * 100000);
      n_bad++;
      $display("FAIL R11 watchdog expired: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      idle(2);
      rst_n = 1'b1;
      idle(1);
      // R11 reset state
      chk("R11 warn after reset", 32'(warn), 0);
      chk("R11 fatal after reset", 32'(fatal), 0);
      rd_chk(8'h40, 0, "R11 enable reads 0");
      rd_chk(8'h5C, 0, "R11 fatal threshold reads 0");

      // R1 / R4 map 0 readback and unmapped address
      wr_reg(8'h4C, 32'h0000_0123);
      rd_chk(8'h4C, 32'h23, "R4 warn threshold keeps low CNT_W bits");
      wr_reg(8'h5C, 32'hFFFF_FFFF);
      rd_chk(8'h5C, 32'hFF, "R4 fatal threshold readback");
      wr_reg(8'h44, 32'hFFFF_FFFF);
      rd_chk(8'h44, 0, "R1 unmapped address reads 0");
      rd_chk(8'h38, 0, "R3 restart reads 0");
      wr_reg(8'h40, 32'hFFFF_FFFE);
      rd_chk(8'h40, 0, "R2 enable stores only bit 0");

      // R1 map 1
      wr_reg1(8'h10, 32'h55);
      @(negedge clk); addr1 = 8'h10; #1; chk("R1 map1 warn threshold at 0x10", rdata1, 32'h55);
      wr_reg1(8'h08, 32'h1);
      @(negedge clk); addr1 = 8'h08; #1; chk("R1 map1 enable at 0x08", rdata1, 32'h1);
      @(negedge clk); addr1 = 8'h4C; #1; chk("R1 map1 ignores map0 address", rdata1, 0);

      // Scenario: warning then fatal, ticks every cycle
      do_reset();
      tick_mode = 1;
      wr_reg(8'h40, 0); wr_reg(8'h38, 1);
      wr_reg(8'h4C, 10); wr_reg(8'h5C, 20);
      wr_reg(8'h40, 1);
      idle(15);
      chk("R5 warn raised", 32'(warn), 1);
      chk("R6 fatal not yet", 32'(fatal), 0);
      wr_reg(8'h38, 1);
      chk("R5 restart clears warn", 32'(warn), 0);
      idle(5);
      wr_reg(8'h38, 0);
      idle(8);
      chk("R3 restart with bit0 clear has no effect", 32'(warn), 1);
      wr_reg(8'h40, 0);
      idle(1);
      chk("R5 disable clears warn", 32'(warn), 0);
      wr_reg(8'h40, 1);
      idle(12);
      chk("R6 fatal raised", 32'(fatal), 1);
      wr_reg(8'h38, 1); wr_reg(8'h40, 0);
      idle(3);
      chk("R6 fatal holds through restart and disable", 32'(fatal), 1);
      do_reset();
      idle(1);
      chk("R11 reset clears fatal", 32'(fatal), 0);

      // R7 fatal below warning, slow ticks
      tick_mode = 2;
      wr_reg(8'h4C, 50); wr_reg(8'h5C, 10); wr_reg(8'h38, 1); wr_reg(8'h40, 1);
      idle(220);
      chk("R7 fatal fires first", 32'(fatal), 1);
      chk("R7 no warning after fatal", 32'(warn), 0);

      // R8 one-tick reset
      do_reset();
      tick_mode = 1;
      wr_reg(8'h40, 0); wr_reg(8'h38, 1); wr_reg(8'h5C, 1); wr_reg(8'h4C, 0);
      wr_reg(8'h40, 1);
      idle(1);
      chk("R8 fatal low after first edge", 32'(fatal), 0);
      idle(1);
      chk("R8 fatal high after second edge", 32'(fatal), 1);

      // R9 zero thresholds never fire
      do_reset();
      wr_reg(8'h38, 1); wr_reg(8'h40, 1);
      idle(400);
      chk("R9 warn with zero threshold", 32'(warn), 0);
      chk("R9 fatal with zero threshold", 32'(fatal), 0);

      // R10 saturation seen through re-enable
      wr_reg(8'h4C, MAXC);
      idle(20);
      chk("R10 warn at max count", 32'(warn), 1);
      wr_reg(8'h40, 0);
      idle(2);
      chk("R10 warn cleared by disable", 32'(warn), 0);
      wr_reg(8'h40, 1);
      idle(3);
      chk("R10 saturated count refires warn", 32'(warn), 1);

      // R2 no counting without tick
      do_reset();
      tick_mode = 0;
      wr_reg(8'h4C, 2); wr_reg(8'h38, 1); wr_reg(8'h40, 1);
      idle(20);
      chk("R2 no tick keeps warn low", 32'(warn), 0);
      tick_mode = 2;
      idle(20);
      chk("R2 ticks advance count to warn", 32'(warn), 1);

      idle(2);
      summary();
      $finish;
   end

endmodule